// File: doc/BRIEF.md
# Dead-Time Compensated Sine PWM Leg Modulator

This block drives the two gates of one half-bridge inverter leg. A triangular carrier counts up and down between zero and its full span. At every carrier corner, a sine reference is sampled: it comes from a quarter-wave table indexed by a phase accumulator, and it is scaled by a modulation index. That sampled level is the threshold for a comparison against the carrier, which gives a nominal switching signal. Two delay stages turn the nominal signal into the high-side and low-side gates. Each gate's turn-on is held back by a programmable dead time, so the two switches never conduct together.

Dead time makes the leg voltage depend on the direction of the load current. To cancel that error, the comparison threshold is moved by an offset. The offset depends on the current sign and on the direction the carrier is currently moving. With a carrier span of `2^CAR_BITS` counts and a period of twice that many cycles, the offset 2·d·span/period reduces to exactly `deadTime` counts. The shifted threshold is clamped to the carrier range. The parent supplies the modulation index, the phase step per carrier corner, the current sign and the dead time. Current sensing and closed-loop regulation stay outside.

Top module: `dtc_spwm_leg`

## Requirements
- R1: The carrier counts 0,1,…,CMAX (CMAX = 2^CAR_BITS = 128), then back down to 1 and round again, moving by exactly one count every cycle. Its period is 2·CMAX cycles. The rising half covers counts 0…CMAX−1 and the falling half covers counts CMAX…1.
- R2: The reference level is loaded only in a cycle where the carrier is at 0 or at CMAX, and the new value is used from the following cycle. The phase accumulator advances by `phaseStep` at each of those same corners.
- R3: Reference level = CMAX/2 + floor(s·modIndex / 2^(SIN_BITS−1+MOD_BITS−CAR_BITS+1)), where `modIndex` is unsigned and 255 stands for full scale. The sine value s is built as follows:
  - The top two phase bits select the quadrant, and the next LUT_BITS bits form the table index.
  - Quadrants 1 and 3 mirror the index.
  - Quadrants 2 and 3 negate the value.
  - Table entry k equals round(127·sin(π(k+0.5)/128)).
- R4: When `currentPos`=1, the threshold is the reference level on the rising half and the reference level + `deadTime` on the falling half.
- R5: When `currentPos`=0, the threshold is the reference level − `deadTime` on the rising half and the reference level on the falling half.
- R6: The threshold is clamped to the range 0…CMAX before the comparison. The nominal signal is 1 while threshold > carrier.
- R7: `gateHigh` follows the nominal signal and `gateLow` follows its inverse. Each gate falls one cycle after its target falls. Each gate rises `deadTime`+1 cycles after its target rises, so both gates are low for `deadTime` cycles at every transition.
- R8: `gateHigh` and `gateLow` are never high in the same cycle.
- R9: While `rstN` is low, both gates are low. Reset leaves the carrier at 0 on its rising half, the reference level at CMAX/2 and the phase at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modIndex | input | MOD_BITS | Modulation index, unsigned, 255 is full scale |
| phaseStep | input | PH_BITS | Phase increment applied at each carrier corner |
| currentPos | input | 1 | Load current sign: 1 is positive, 0 is negative |
| deadTime | input | DT_BITS | Dead time in clock cycles, equal to the threshold offset in counts |
| gateHigh | output | 1 | High-side switch gate |
| gateLow | output | 1 | Low-side switch gate |

## Verification
The following are checked on every cycle:
- the gates never overlap;
- the carrier moves one count per cycle and stays within its span;
- a reference load is followed by the first step away from a corner;
- any gate turn-on is preceded by at least the programmed number of both-low cycles.

Some behaviours can only be shown by the bench's scenarios, because they depend on whole carrier periods:
- the widths of each gate pulse per period under both current signs;
- the offset moving the correct edge in the correct direction;
- the clamping at both ends of the carrier;
- the sine scaling, which the bench observes as the longest gate pulse while the phase steps by a quarter turn.

// File: rtl/spwm_pkg.sv
package spwm_pkg;
  typedef struct packed {
    logic sampleStb;  // carrier sits at a corner this cycle
    logic slopeUp;    // carrier is on its rising half
  } strobe_t;
endpackage

// File: rtl/spwm_ctrl.sv
module spwm_ctrl #(
  parameter int CAR_BITS = 7,
  parameter int PH_BITS  = 16,
  parameter int LUT_BITS = 6
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [PH_BITS-1:0]        phaseStep,
  output logic [CAR_BITS:0]         carrier,
  output logic [LUT_BITS+1:0]       phaseTop,
  output spwm_pkg::strobe_t         strb
);
  localparam int CW   = CAR_BITS + 1;
  localparam int CMAX = 2 ** CAR_BITS;

  logic [CW-1:0]      cntQ;
  logic               upQ;
  logic [PH_BITS-1:0] phaseQ;
  logic               corner;

  assign corner = (cntQ == CW'(0)) || (cntQ == CW'(CMAX));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ   <= '0;
      upQ    <= 1'b1;
      phaseQ <= '0;
    end else begin
      cntQ <= upQ ? cntQ + CW'(1) : cntQ - CW'(1);
      if (upQ && cntQ == CW'(CMAX - 1)) upQ <= 1'b0;
      else if (!upQ && cntQ == CW'(1))  upQ <= 1'b1;
      if (corner) phaseQ <= phaseQ + phaseStep;
    end
  end

  assign carrier        = cntQ;
  assign phaseTop       = phaseQ[PH_BITS-1 -: LUT_BITS+2];
  assign strb.sampleStb = corner;
  assign strb.slopeUp   = upQ;
endmodule

// File: rtl/spwm_deadtime.sv
module spwm_deadtime #(
  parameter int DT_BITS = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               want,
  input  logic [DT_BITS-1:0] delay,
  output logic               gate
);
  logic [DT_BITS-1:0] dlyQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gate <= 1'b0;
      dlyQ <= '0;
    end else if (!want) begin
      gate <= 1'b0;
      dlyQ <= '0;
    end else if (!gate) begin
      if (dlyQ >= delay) gate <= 1'b1;
      else               dlyQ <= dlyQ + DT_BITS'(1);
    end
  end
endmodule

// File: rtl/spwm_datapath.sv
module spwm_datapath #(
  parameter int CAR_BITS = 7,
  parameter int MOD_BITS = 8,
  parameter int LUT_BITS = 6,
  parameter int SIN_BITS = 8,
  parameter int DT_BITS  = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  spwm_pkg::strobe_t    strb,
  input  logic [CAR_BITS:0]    carrier,
  input  logic [LUT_BITS+1:0]  phaseTop,
  input  logic [MOD_BITS-1:0]  modIndex,
  input  logic                 currentPos,
  input  logic [DT_BITS-1:0]   deadTime,
  output logic                 gateHigh,
  output logic                 gateLow
);
  localparam int QN   = 2 ** LUT_BITS;
  localparam int AMP  = 2 ** (SIN_BITS - 1) - 1;
  localparam int HALF = 2 ** (CAR_BITS - 1);
  localparam int CMAX = 2 ** CAR_BITS;
  localparam int SH   = SIN_BITS - 1 + MOD_BITS - (CAR_BITS - 1);
  localparam int PW   = SIN_BITS + MOD_BITS + 1;
  localparam int RW   = CAR_BITS + 1;
  localparam int TW   = ((CAR_BITS > DT_BITS) ? CAR_BITS : DT_BITS) + 3;
  localparam logic signed [TW-1:0] CMAX_S = TW'(CMAX);

  // quarter-wave sine table, filled from constants at elaboration
  logic [SIN_BITS-2:0] lut [QN];
  for (genvar k = 0; k < QN; k++) begin : g_lut
    localparam real ANG = 3.14159265358979 * (real'(k) + 0.5) / (2.0 * real'(QN));
    localparam int  VAL = $rtoi(real'(AMP) * $sin(ANG) + 0.5);
    assign lut[k] = (SIN_BITS-1)'(VAL);
  end

  logic [1:0]                quad;
  logic [LUT_BITS-1:0]       idx, addr;
  logic [SIN_BITS-2:0]       mag;
  logic signed [SIN_BITS-1:0] sineVal;
  logic signed [MOD_BITS:0]  modS;
  logic signed [PW-1:0]      prod;
  logic [RW-1:0]             refNext, vphQ;

  assign quad    = phaseTop[LUT_BITS+1 -: 2];
  assign idx     = phaseTop[LUT_BITS-1:0];
  assign addr    = quad[0] ? ~idx : idx;
  assign mag     = lut[addr];
  assign sineVal = quad[1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
  assign modS    = $signed({1'b0, modIndex});
  assign prod    = PW'(sineVal) * PW'(modS);
  assign refNext = RW'(prod >>> SH) + RW'(HALF);

  // regular sampling: reference held between carrier corners
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              vphQ <= RW'(HALF);
    else if (strb.sampleStb) vphQ <= refNext;
  end

  // current- and slope-dependent threshold shift, then clamp
  logic signed [TW-1:0] vphS, dS, thrWide;
  logic [RW-1:0]        thrSat;
  logic                 nominal;

  assign vphS = signed'(TW'(vphQ));
  assign dS   = signed'(TW'(deadTime));

  always_comb begin
    if (strb.slopeUp) thrWide = currentPos ? vphS : vphS - dS;
    else              thrWide = currentPos ? vphS + dS : vphS;
    if (thrWide < 0)           thrSat = '0;
    else if (thrWide > CMAX_S) thrSat = RW'(CMAX);
    else                       thrSat = thrWide[RW-1:0];
  end

  assign nominal = thrSat > carrier;

  logic [1:0] gateVec;
  for (genvar g = 0; g < 2; g++) begin : g_leg
    spwm_deadtime #(.DT_BITS(DT_BITS)) uDt (
      .clk  (clk),
      .rstN (rstN),
      .want ((g == 0) ? nominal : !nominal),
      .delay(deadTime),
      .gate (gateVec[g])
    );
  end

  assign gateHigh = gateVec[0];
  assign gateLow  = gateVec[1];
endmodule

// File: rtl/dtc_spwm_leg.sv
module dtc_spwm_leg #(
  parameter int CAR_BITS = 7,
  parameter int MOD_BITS = 8,
  parameter int PH_BITS  = 16,
  parameter int LUT_BITS = 6,
  parameter int SIN_BITS = 8,
  parameter int DT_BITS  = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [MOD_BITS-1:0] modIndex,
  input  logic [PH_BITS-1:0]  phaseStep,
  input  logic                currentPos,
  input  logic [DT_BITS-1:0]  deadTime,
  output logic                gateHigh,
  output logic                gateLow
);
  spwm_pkg::strobe_t     strb;
  logic [CAR_BITS:0]     carrier;
  logic [LUT_BITS+1:0]   phaseTop;

  spwm_ctrl #(.CAR_BITS(CAR_BITS), .PH_BITS(PH_BITS), .LUT_BITS(LUT_BITS)) uCtrl (
    .clk(clk), .rstN(rstN), .phaseStep(phaseStep),
    .carrier(carrier), .phaseTop(phaseTop), .strb(strb)
  );

  spwm_datapath #(.CAR_BITS(CAR_BITS), .MOD_BITS(MOD_BITS), .LUT_BITS(LUT_BITS),
                  .SIN_BITS(SIN_BITS), .DT_BITS(DT_BITS)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .carrier(carrier), .phaseTop(phaseTop),
    .modIndex(modIndex), .currentPos(currentPos), .deadTime(deadTime),
    .gateHigh(gateHigh), .gateLow(gateLow)
  );
endmodule

// File: rtl/spwm_leg_chk.sv
module spwm_leg_chk #(
  parameter int CAR_BITS = 7,
  parameter int DT_BITS  = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic [CAR_BITS:0]  carrier,
  input spwm_pkg::strobe_t  strb,
  input logic               gateHigh,
  input logic               gateLow,
  input logic [DT_BITS-1:0] deadTime
);
  localparam int CMAX = 2 ** CAR_BITS;

  logic        seenQ;
  logic [15:0] lowRunQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seenQ   <= 1'b0;
      lowRunQ <= '0;
    end else begin
      seenQ <= 1'b1;
      if (gateHigh || gateLow)  lowRunQ <= '0;
      else if (lowRunQ != '1)   lowRunQ <= lowRunQ + 16'd1;
    end
  end

  // R9: gates held low during reset
  a_r9_reset_low: assert property (@(posedge clk) !rstN |-> (!gateHigh && !gateLow));

  // R1: carrier within span and moving one count per cycle
  a_r1_carrier_span: assert property (@(posedge clk) disable iff (!rstN)
    carrier <= (CAR_BITS+1)'(CMAX));
  a_r1_carrier_step: assert property (@(posedge clk) disable iff (!rstN)
    seenQ |-> ((carrier == $past(carrier) + 1'b1) || (carrier == $past(carrier) - 1'b1)));

  // R2: a reference load happens at a corner, so the next count is one step inside
  a_r2_corner_sample: assert property (@(posedge clk) disable iff (!rstN)
    strb.sampleStb |=> (carrier == (CAR_BITS+1)'(1) || carrier == (CAR_BITS+1)'(CMAX - 1)));

  // R8: no shoot-through
  a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(gateHigh && gateLow));

  // R7: any turn-on is preceded by at least the dead time of both-low cycles
  a_r7_high_gap: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateHigh) |-> lowRunQ >= 16'($past(deadTime)));
  a_r7_low_gap: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateLow) |-> lowRunQ >= 16'($past(deadTime)));
endmodule

bind dtc_spwm_leg spwm_leg_chk #(.CAR_BITS(CAR_BITS), .DT_BITS(DT_BITS)) uChk (
  .clk(clk), .rstN(rstN), .carrier(carrier), .strb(strb),
  .gateHigh(gateHigh), .gateLow(gateLow), .deadTime(deadTime)
);

// File: tb/tb_dtc_spwm_leg.sv
module tb_dtc_spwm_leg;
  localparam int PER = 256;  // carrier period in cycles

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  modIndex = '0;
  logic [15:0] phaseStep = '0;
  logic        currentPos = 1'b1;
  logic [7:0]  deadTime = '0;
  logic        gateHigh, gateLow;

  int errors = 0;
  int checks = 0;
  int hiCnt, loCnt, gapCnt, ovCnt, maxRun;

  dtc_spwm_leg dut (
    .clk(clk), .rstN(rstN), .modIndex(modIndex), .phaseStep(phaseStep),
    .currentPos(currentPos), .deadTime(deadTime),
    .gateHigh(gateHigh), .gateLow(gateLow)
  );

  always #4 clk = ~clk;

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog (R1..R9 run) actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(input int n);
    int run = 0;
    hiCnt = 0; loCnt = 0; gapCnt = 0; ovCnt = 0; maxRun = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (gateHigh) hiCnt++;
      if (gateLow) loCnt++;
      if (!gateHigh && !gateLow) gapCnt++;
      if (gateHigh && gateLow) ovCnt++;
      run = gateHigh ? run + 1 : 0;
      if (run > maxRun) maxRun = run;
    end
  endtask

  // columns: currentPos, deadTime, modIndex, high count, low count, both-low count per period
  localparam int VEC [8][6] = '{
    '{1,   0,   0, 127, 129,   0},   // R4 no offset
    '{1,   5,   0, 127, 119,  10},   // R4 falling edge shifted up
    '{0,   5,   0, 117, 129,  10},   // R5 rising edge shifted down
    '{1,  20,  77, 127,  89,  40},   // R4
    '{0,  20,  77,  87, 129,  40},   // R5
    '{1,  70,   0, 121,   0, 135},   // R6 clamp at top
    '{0, 100,   0,   0,  93, 163},   // R6 clamp at zero
    '{0,   0, 200, 127, 129,   0}    // R5 zero dead time
  };

  initial begin
    // R9 reset state
    deadTime = 8'd3;
    repeat (3) @(negedge clk);
    chk("R9 gateHigh in reset", int'(gateHigh), 0);
    chk("R9 gateLow in reset", int'(gateLow), 0);
    rstN = 1'b1;

    // R7 first turn-on after reset delayed by deadTime+1 cycles
    repeat (3) @(negedge clk);
    chk("R7 gateHigh before delay", int'(gateHigh), 0);
    @(negedge clk);
    chk("R7 gateHigh after delay", int'(gateHigh), 1);
    chk("R7 gateLow stays low", int'(gateLow), 0);

    // R1 carrier period seen as spacing of gateHigh rising edges
    begin
      int t = 0;
      while (gateHigh) @(negedge clk);
      while (!gateHigh) @(negedge clk);
      do begin @(negedge clk); t++; end while (gateHigh);
      while (!gateHigh) begin @(negedge clk); t++; end
      chk("R1 carrier period", t, PER);
    end

    // table walk: R4 R5 R6 R7 R8
    for (int v = 0; v < 8; v++) begin
      currentPos = VEC[v][0][0];
      deadTime   = 8'(VEC[v][1]);
      modIndex   = 8'(VEC[v][2]);
      repeat (3 * PER) @(negedge clk);
      measure(PER);
      chk($sformatf("R4/R5/R6 high width vec%0d", v), hiCnt, VEC[v][3]);
      chk($sformatf("R4/R5/R6 low width vec%0d", v), loCnt, VEC[v][4]);
      chk($sformatf("R7 dead gap vec%0d", v), gapCnt, VEC[v][5]);
      chk($sformatf("R8 overlap vec%0d", v), ovCnt, 0);
    end

    // R3 and R2: quarter-turn phase steps at each corner, full index
    currentPos = 1'b1;
    deadTime   = 8'd0;
    modIndex   = 8'd255;
    phaseStep  = 16'h4000;
    repeat (4 * PER) @(negedge clk);
    measure(4 * PER);
    chk("R3 longest pulse with full index", maxRun, 189);
    chk("R8 overlap with sine", ovCnt, 0);

    modIndex = 8'd0;
    repeat (4 * PER) @(negedge clk);
    measure(4 * PER);
    chk("R3 longest pulse with zero index", maxRun, 127);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule